// File: doc/BRIEF.md
# Critical-Sub-Block Priority Request Splitter

This block sits between a cache miss handler and a DRAM scheduler. Each cache-line fill it accepts names a line address and the sub-block that holds the word the processor is waiting for. The block holds the line in a small table of outstanding fills and breaks it into fixed-size sub-block requests for the DRAM side. Every request carries a priority bit. The critical sub-block is marked high and leaves first. The remaining sub-blocks are marked low and follow in wrap order after the critical one.

Several fills may be in flight at once. When a later miss lands on a different sub-block of a line that is still outstanding, the matching request is raised to high priority, provided it has not left yet. DRAM responses may arrive in any order. Each one is handed back to the requester as a single sub-block, tagged with the line's table slot and the sub-block index. A table slot is released once all of its sub-blocks have come back. While every slot is busy, new misses are held off.

The defaults are a 64-byte line cut into four 16-byte sub-blocks and four table slots. A sub-block is never smaller than the 16-byte minimum DRAM request.

Top module: `subblk_prio_splitter`

## Requirements
- R1: After reset `req_valid` and `ret_valid` are low and `miss_ready` is high.
- R2: Each accepted miss leads to exactly four requests for that line, one for each sub-block index 0 to 3. Each carries the line address and the slot id. No sub-block is requested twice, and at most one request leaves per cycle (a request leaves in a cycle where `req_valid` and `req_ready` are both high).
- R3: Within one line, the critical sub-block (`miss_crit`) leaves first with `req_hi` = 1. The others leave with `req_hi` = 0 in the order crit+1, crit+2, crit+3, taken modulo 4.
- R4: While any pending sub-block is high priority, a high-priority one is issued first, taken from the oldest line that has one. Only when none is pending is the oldest line with a pending low sub-block served. Inside a line, the wrap order of R3 applies to each priority class.
- R5: A secondary miss (`sec_valid`, `sec_line`, `sec_sub`) that matches an outstanding line and names a sub-block that has not yet been issued raises that sub-block to high priority from the next cycle on.
- R6: A secondary miss that names a sub-block already issued or already returned, or a line that is not outstanding, changes neither the request order nor the priorities.
- R7: A response (`rsp_valid`, `rsp_id`, `rsp_sub`, `rsp_data`) appears on `ret_valid`/`ret_id`/`ret_sub`/`ret_data` exactly one cycle later, whatever order responses come in. With no response, `ret_valid` is low one cycle later.
- R8: `miss_id` names the lowest free slot. A slot is freed at the clock edge that takes in its fourth response. `miss_ready` is low exactly while all four slots are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | New line fill request |
| miss_ready | output | 1 | A table slot is free |
| miss_line | input | LINE_ADDR_W | Line address of the fill |
| miss_crit | input | SW | Index of the critical sub-block |
| miss_id | output | IW | Slot that an accepted miss takes |
| sec_valid | input | 1 | Secondary miss to a line in flight |
| sec_line | input | LINE_ADDR_W | Line address of the secondary miss |
| sec_sub | input | SW | Sub-block the secondary miss needs |
| req_valid | output | 1 | A sub-block request is offered |
| req_ready | input | 1 | DRAM side takes the request |
| req_line | output | LINE_ADDR_W | Line address of the request |
| req_id | output | IW | Slot of the request |
| req_sub | output | SW | Sub-block index of the request |
| req_hi | output | 1 | Priority tag, 1 = high |
| rsp_valid | input | 1 | Sub-block data back from DRAM |
| rsp_id | input | IW | Slot of the response |
| rsp_sub | input | SW | Sub-block index of the response |
| rsp_data | input | DW | Sub-block data |
| ret_valid | output | 1 | Sub-block returned to requester |
| ret_id | output | IW | Slot of the returned sub-block |
| ret_sub | output | SW | Index of the returned sub-block |
| ret_data | output | DW | Returned data |

## Verification
The bench piles up several lines while `req_ready` is held low, so that the arbiter must choose among them. It checks that a younger line's raised sub-block overtakes an older line's low ones, and that a design ordering only by age, or only by slot index, would issue in the wrong sequence. It sends secondary misses to a sub-block already issued, to one already returned, and to an unknown line. A design that re-arms or promotes the wrong entry would then produce a duplicate or reordered request. It fills all four slots, returns one line out of order and checks that the freed slot is reused at once and that `miss_ready` drops and rises at the right edge.

// File: rtl/spl_pkg.sv
package spl_pkg;

    // Life cycle of one sub-block inside an outstanding line
    typedef enum logic [1:0] {
        SB_EMPTY  = 2'd0,
        SB_PEND   = 2'd1,
        SB_ISSUED = 2'd2,
        SB_DONE   = 2'd3
    } sb_state_e;

endpackage

// File: rtl/spl_sub_pick.sv
// Chooses, inside one line, the first pending sub-block in wrap order
// starting at the critical index: once among high-priority ones, once
// among all pending ones.
module spl_sub_pick #(
    parameter int SUBS = 4,
    localparam int SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
    input  logic [SUBS-1:0] pend,
    input  logic [SUBS-1:0] hi,
    input  logic [SW-1:0]   crit,
    output logic            hi_any,
    output logic            lo_any,
    output logic [SW-1:0]   hi_sub,
    output logic [SW-1:0]   lo_sub
);

    always_comb begin
        int idx;
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_sub = '0;
        lo_sub = '0;
        idx    = 0;
        for (int k = 0; k < SUBS; k++) begin
            idx = (int'(crit) + k) % SUBS;
            if (!hi_any && pend[idx] && hi[idx]) begin
                hi_any = 1'b1;
                hi_sub = SW'(idx);
            end
            if (!lo_any && pend[idx]) begin
                lo_any = 1'b1;
                lo_sub = SW'(idx);
            end
        end
    end

endmodule

// File: rtl/spl_age_matrix.sv
// Relative age of the table slots. older[i][j] set means slot i was
// allocated before slot j. Gives the oldest slot of two candidate sets.
module spl_age_matrix #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [IW-1:0] alloc_idx,
    input  logic [N-1:0]  cand_hi,
    input  logic [N-1:0]  cand_lo,
    output logic [IW-1:0] pick_hi,
    output logic [IW-1:0] pick_lo
);

    typedef struct packed {
        logic [N-1:0][N-1:0] older;
    } age_t;

    age_t age_d, age_q;

    function automatic logic [IW-1:0] f_oldest(input logic [N-1:0] cand,
                                               input logic [N-1:0][N-1:0] ord);
        logic [IW-1:0] res;
        logic          found;
        logic          beaten;
        res   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            beaten = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (cand[j] && ord[j][i]) beaten = 1'b1;
            end
            if (!found && cand[i] && !beaten) begin
                res   = IW'(i);
                found = 1'b1;
            end
        end
        return res;
    endfunction

    always_comb begin
        age_d = age_q;
        if (alloc_en) begin
            for (int j = 0; j < N; j++) begin
                age_d.older[alloc_idx][j] = 1'b0;
                age_d.older[j][alloc_idx] = (IW'(j) != alloc_idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    assign pick_hi = f_oldest(cand_hi, age_q.older);
    assign pick_lo = f_oldest(cand_lo, age_q.older);

endmodule

// File: rtl/subblk_prio_splitter.sv
module subblk_prio_splitter
    import spl_pkg::*;
#(
    parameter int LINE_ADDR_W = 26,
    parameter int NUM_LINES   = 4,
    parameter int LINE_BYTES  = 64,
    parameter int SUB_BYTES   = 16,
    localparam int SUBS = LINE_BYTES / SUB_BYTES,
    localparam int SW   = (SUBS > 1) ? $clog2(SUBS) : 1,
    localparam int IW   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int DW   = SUB_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   miss_valid,
    output logic                   miss_ready,
    input  logic [LINE_ADDR_W-1:0] miss_line,
    input  logic [SW-1:0]          miss_crit,
    output logic [IW-1:0]          miss_id,
    input  logic                   sec_valid,
    input  logic [LINE_ADDR_W-1:0] sec_line,
    input  logic [SW-1:0]          sec_sub,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [LINE_ADDR_W-1:0] req_line,
    output logic [IW-1:0]          req_id,
    output logic [SW-1:0]          req_sub,
    output logic                   req_hi,
    input  logic                   rsp_valid,
    input  logic [IW-1:0]          rsp_id,
    input  logic [SW-1:0]          rsp_sub,
    input  logic [DW-1:0]          rsp_data,
    output logic                   ret_valid,
    output logic [IW-1:0]          ret_id,
    output logic [SW-1:0]          ret_sub,
    output logic [DW-1:0]          ret_data
);

    typedef struct packed {
        logic                   vld;
        logic [LINE_ADDR_W-1:0] line;
        logic [SW-1:0]          crit;
        sb_state_e [SUBS-1:0]   sb;
        logic [SUBS-1:0]        hi;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_LINES-1:0] ent;
        logic                   ret_vld;
        logic [IW-1:0]          ret_id;
        logic [SW-1:0]          ret_sub;
        logic [DW-1:0]          ret_data;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_LINES-1:0]         hi_any;
    logic [NUM_LINES-1:0]         lo_any;
    logic [NUM_LINES-1:0][SW-1:0] hi_sub;
    logic [NUM_LINES-1:0][SW-1:0] lo_sub;
    logic [IW-1:0]                pick_hi;
    logic [IW-1:0]                pick_lo;
    logic [IW-1:0]                alloc_idx;
    logic                         alloc_en;
    logic                         use_hi;

    // Free slot search: lowest index wins
    always_comb begin
        alloc_idx  = '0;
        miss_ready = 1'b0;
        for (int l = NUM_LINES - 1; l >= 0; l--) begin
            if (!state_q.ent[l].vld) begin
                alloc_idx  = IW'(l);
                miss_ready = 1'b1;
            end
        end
    end

    assign miss_id  = alloc_idx;
    assign alloc_en = miss_valid && miss_ready;

    // Per-line sub-block choice
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [SUBS-1:0] pend;
        always_comb begin
            for (int s = 0; s < SUBS; s++) begin
                pend[s] = state_q.ent[g].vld && (state_q.ent[g].sb[s] == SB_PEND);
            end
        end
        spl_sub_pick #(.SUBS(SUBS)) u_pick (
            .pend   (pend),
            .hi     (state_q.ent[g].hi),
            .crit   (state_q.ent[g].crit),
            .hi_any (hi_any[g]),
            .lo_any (lo_any[g]),
            .hi_sub (hi_sub[g]),
            .lo_sub (lo_sub[g])
        );
    end

    spl_age_matrix #(.N(NUM_LINES)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx),
        .cand_hi   (hi_any),
        .cand_lo   (lo_any),
        .pick_hi   (pick_hi),
        .pick_lo   (pick_lo)
    );

    // Request selection: high class first, oldest line inside a class
    assign use_hi    = |hi_any;
    assign req_valid = |lo_any;
    assign req_id    = use_hi ? pick_hi : pick_lo;
    assign req_sub   = use_hi ? hi_sub[pick_hi] : lo_sub[pick_lo];
    assign req_line  = state_q.ent[req_id].line;
    assign req_hi    = state_q.ent[req_id].hi[req_sub];

    // Next state
    always_comb begin
        logic all_done;
        state_d  = state_q;
        all_done = 1'b0;

        // Return path: one register stage
        state_d.ret_vld = rsp_valid;
        if (rsp_valid) begin
            state_d.ret_id   = rsp_id;
            state_d.ret_sub  = rsp_sub;
            state_d.ret_data = rsp_data;
        end

        // Secondary miss promotes a still-pending sub-block
        if (sec_valid) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (state_q.ent[l].vld && state_q.ent[l].line == sec_line &&
                    state_q.ent[l].sb[sec_sub] == SB_PEND) begin
                    state_d.ent[l].hi[sec_sub] = 1'b1;
                end
            end
        end

        // Issue
        if (req_valid && req_ready) begin
            state_d.ent[req_id].sb[req_sub] = SB_ISSUED;
        end

        // Response marks the sub-block complete
        if (rsp_valid && state_q.ent[rsp_id].vld) begin
            state_d.ent[rsp_id].sb[rsp_sub] = SB_DONE;
        end

        // Release fully returned lines
        for (int l = 0; l < NUM_LINES; l++) begin
            all_done = 1'b1;
            for (int s = 0; s < SUBS; s++) begin
                if (state_d.ent[l].sb[s] != SB_DONE) all_done = 1'b0;
            end
            if (state_q.ent[l].vld && all_done) begin
                state_d.ent[l].vld = 1'b0;
                for (int s = 0; s < SUBS; s++) begin
                    state_d.ent[l].sb[s] = SB_EMPTY;
                end
                state_d.ent[l].hi = '0;
            end
        end

        // Allocate a new line; the critical sub-block starts high
        if (alloc_en) begin
            state_d.ent[alloc_idx].vld  = 1'b1;
            state_d.ent[alloc_idx].line = miss_line;
            state_d.ent[alloc_idx].crit = miss_crit;
            for (int s = 0; s < SUBS; s++) begin
                state_d.ent[alloc_idx].sb[s] = SB_PEND;
                state_d.ent[alloc_idx].hi[s] = (SW'(s) == miss_crit);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ret_valid = state_q.ret_vld;
    assign ret_id    = state_q.ret_id;
    assign ret_sub   = state_q.ret_sub;
    assign ret_data  = state_q.ret_data;

endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
    parameter int NUM_LINES = 4,
    parameter int SUBS      = 4,
    parameter int DW        = 128,
    localparam int SW = (SUBS > 1) ? $clog2(SUBS) : 1,
    localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 miss_valid,
    input logic                 miss_ready,
    input logic [IW-1:0]        miss_id,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [IW-1:0]        req_id,
    input logic [SW-1:0]        req_sub,
    input logic                 req_hi,
    input logic                 rsp_valid,
    input logic [IW-1:0]        rsp_id,
    input logic [SW-1:0]        rsp_sub,
    input logic [DW-1:0]        rsp_data,
    input logic                 ret_valid,
    input logic [IW-1:0]        ret_id,
    input logic [SW-1:0]        ret_sub,
    input logic [DW-1:0]        ret_data,
    input logic [NUM_LINES-1:0] hi_any
);

    // Shadow occupancy built from port traffic only
    typedef struct packed {
        logic [NUM_LINES-1:0][SUBS-1:0] issued;
        logic [NUM_LINES-1:0]           busy;
        logic [NUM_LINES-1:0][SW:0]     cnt;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (rsp_valid && sh_q.busy[rsp_id]) begin
            if (sh_q.cnt[rsp_id] == (SW+1)'(SUBS - 1)) begin
                sh_d.busy[rsp_id] = 1'b0;
                sh_d.cnt[rsp_id]  = '0;
            end else begin
                sh_d.cnt[rsp_id] = sh_q.cnt[rsp_id] + 1'b1;
            end
        end
        if (req_valid && req_ready) sh_d.issued[req_id][req_sub] = 1'b1;
        if (miss_valid && miss_ready) begin
            sh_d.busy[miss_id]   = 1'b1;
            sh_d.cnt[miss_id]    = '0;
            sh_d.issued[miss_id] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!req_valid && !ret_valid && miss_ready));

    assert_no_dup_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !sh_q.issued[req_id][req_sub]);

    assert_issue_live_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> sh_q.busy[req_id]);

    assert_hi_before_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hi) |-> (hi_any == '0));

    assert_ret_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (ret_valid && ret_id == $past(rsp_id) &&
                       ret_sub == $past(rsp_sub) && ret_data == $past(rsp_data)));

    assert_ret_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> !ret_valid);

    assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&sh_q.busy) |-> !miss_ready);

    assert_free_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sh_q.busy) |-> miss_ready);

    assert_alloc_free_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |-> !sh_q.busy[miss_id]);

endmodule

bind subblk_prio_splitter spl_checker #(
    .NUM_LINES (NUM_LINES),
    .SUBS      (SUBS),
    .DW        (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .miss_id    (miss_id),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_id     (req_id),
    .req_sub    (req_sub),
    .req_hi     (req_hi),
    .rsp_valid  (rsp_valid),
    .rsp_id     (rsp_id),
    .rsp_sub    (rsp_sub),
    .rsp_data   (rsp_data),
    .ret_valid  (ret_valid),
    .ret_id     (ret_id),
    .ret_sub    (ret_sub),
    .ret_data   (ret_data),
    .hi_any     (hi_any)
);

// File: tb/subblk_prio_splitter_tb.sv
module subblk_prio_splitter_tb;

    localparam int LA = 26;
    localparam int SW = 2;
    localparam int IW = 2;
    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic          miss_ready;
    logic [LA-1:0] miss_line = '0;
    logic [SW-1:0] miss_crit = '0;
    logic [IW-1:0] miss_id;
    logic          sec_valid = 1'b0;
    logic [LA-1:0] sec_line = '0;
    logic [SW-1:0] sec_sub = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [LA-1:0] req_line;
    logic [IW-1:0] req_id;
    logic [SW-1:0] req_sub;
    logic          req_hi;
    logic          rsp_valid = 1'b0;
    logic [IW-1:0] rsp_id = '0;
    logic [SW-1:0] rsp_sub = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          ret_valid;
    logic [IW-1:0] ret_id;
    logic [SW-1:0] ret_sub;
    logic [DW-1:0] ret_data;

    always #10 clk = ~clk;

    subblk_prio_splitter u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
        .miss_crit(miss_crit), .miss_id(miss_id),
        .sec_valid(sec_valid), .sec_line(sec_line), .sec_sub(sec_sub),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .req_id(req_id), .req_sub(req_sub), .req_hi(req_hi),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_sub(rsp_sub), .rsp_data(rsp_data),
        .ret_valid(ret_valid), .ret_id(ret_id), .ret_sub(ret_sub), .ret_data(ret_data)
    );

    typedef struct packed {
        logic [LA-1:0] line;
        logic [IW-1:0] id;
        logic [SW-1:0] sub;
        logic          hi;
    } req_t;

    typedef struct packed {
        logic [IW-1:0] id;
        logic [SW-1:0] sub;
        logic [DW-1:0] data;
    } ret_t;

    req_t  exp_req[$];
    string exp_tag[$];
    ret_t  exp_ret[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    seq = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_req(input logic [LA-1:0] line, input logic [IW-1:0] id,
                            input logic [SW-1:0] sub, input logic hi, input string tag);
        exp_req.push_back('{line: line, id: id, sub: sub, hi: hi});
        exp_tag.push_back(tag);
    endtask

    // Request monitor: a request leaves at the next edge when valid and ready
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            req_t  got;
            req_t  e;
            string t;
            got = '{line: req_line, id: req_id, sub: req_sub, hi: req_hi};
            if (exp_req.size() == 0) begin
                chk(1'b0, "R2", "unexpected request {line,id,sub,hi}", longint'(got), 0);
            end else begin
                e = exp_req.pop_front();
                t = exp_tag.pop_front();
                chk(got == e, t, "request {line,id,sub,hi}", longint'(got), longint'(e));
            end
        end
    end

    // Return monitor
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            ret_t e;
            if (exp_ret.size() == 0) begin
                chk(1'b0, "R7", "unexpected return {id,sub}", longint'({ret_id, ret_sub}), 0);
            end else begin
                e = exp_ret.pop_front();
                chk(ret_id == e.id && ret_sub == e.sub, "R7", "return {id,sub}",
                    longint'({ret_id, ret_sub}), longint'({e.id, e.sub}));
                chk(ret_data == e.data, "R7", "return data low word",
                    longint'(ret_data[63:0]), longint'(e.data[63:0]));
            end
        end
    end

    task automatic do_miss(input logic [LA-1:0] line, input logic [SW-1:0] crit,
                           input logic [IW-1:0] exp_id);
        miss_valid = 1'b1;
        miss_line  = line;
        miss_crit  = crit;
        #1;
        chk(miss_ready == 1'b1, "R8", "miss_ready before accept", longint'(miss_ready), 1);
        chk(miss_id == exp_id, "R8", "lowest free slot id", longint'(miss_id), longint'(exp_id));
        @(posedge clk); #2;
        miss_valid = 1'b0;
    endtask

    task automatic do_sec(input logic [LA-1:0] line, input logic [SW-1:0] sub);
        sec_valid = 1'b1;
        sec_line  = line;
        sec_sub   = sub;
        @(posedge clk); #2;
        sec_valid = 1'b0;
    endtask

    task automatic do_rsp(input logic [IW-1:0] id, input logic [SW-1:0] sub);
        logic [DW-1:0] d;
        seq++;
        d = {32'(seq) ^ 32'hA5A5_0000, 32'(seq) * 32'h9E37_79B9, 56'(seq), 6'(0), id, sub, 2'b01};
        rsp_valid = 1'b1;
        rsp_id    = id;
        rsp_sub   = sub;
        rsp_data  = d;
        exp_ret.push_back('{id: id, sub: sub, data: d});
        @(posedge clk); #2;
        rsp_valid = 1'b0;
    endtask

    task automatic run(input int n);
        req_ready = 1'b1;
        repeat (n) @(posedge clk);
        #2;
        req_ready = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R1: idle after reset
        chk(req_valid == 1'b0, "R1", "req_valid after reset", longint'(req_valid), 0);
        chk(ret_valid == 1'b0, "R1", "ret_valid after reset", longint'(ret_valid), 0);
        chk(miss_ready == 1'b1, "R1", "miss_ready after reset", longint'(miss_ready), 1);

        // R2/R3: one line, critical sub-block 2, wrap order afterwards
        do_miss(26'h100, 2'd2, 2'd0);
        push_req(26'h100, 0, 2, 1'b1, "R3");
        push_req(26'h100, 0, 3, 1'b0, "R3");
        push_req(26'h100, 0, 0, 1'b0, "R3");
        push_req(26'h100, 0, 1, 1'b0, "R3");
        run(6);
        #1;
        chk(req_valid == 1'b0, "R2", "no fifth request for a line", longint'(req_valid), 0);
        // R7: responses out of order
        do_rsp(0, 1); do_rsp(0, 0); do_rsp(0, 3); do_rsp(0, 2);
        @(posedge clk); #2;

        // R4/R5: two lines, promotions on both
        do_miss(26'h200, 2'd0, 2'd0);
        do_miss(26'h300, 2'd1, 2'd1);
        do_sec(26'h200, 2'd3);
        do_sec(26'h300, 2'd2);
        push_req(26'h200, 0, 0, 1'b1, "R4");
        push_req(26'h200, 0, 3, 1'b1, "R5");
        push_req(26'h300, 1, 1, 1'b1, "R4");
        push_req(26'h300, 1, 2, 1'b1, "R5");
        push_req(26'h200, 0, 1, 1'b0, "R4");
        push_req(26'h200, 0, 2, 1'b0, "R4");
        push_req(26'h300, 1, 3, 1'b0, "R4");
        push_req(26'h300, 1, 0, 1'b0, "R4");
        run(10);
        do_rsp(1, 0); do_rsp(1, 1); do_rsp(1, 2); do_rsp(1, 3);
        do_rsp(0, 2); do_rsp(0, 0); do_rsp(0, 3); do_rsp(0, 1);
        @(posedge clk); #2;

        // R6: secondary misses that must change nothing
        do_miss(26'h400, 2'd1, 2'd0);
        push_req(26'h400, 0, 1, 1'b1, "R3");
        run(1);
        do_sec(26'h400, 2'd1);   // already issued
        do_sec(26'h7FF, 2'd2);   // line not outstanding
        do_rsp(0, 1);
        do_sec(26'h400, 2'd1);   // already returned
        push_req(26'h400, 0, 2, 1'b0, "R6");
        push_req(26'h400, 0, 3, 1'b0, "R6");
        push_req(26'h400, 0, 0, 1'b0, "R6");
        run(5);
        do_rsp(0, 2); do_rsp(0, 3); do_rsp(0, 0);
        @(posedge clk); #2;

        // R8: fill all slots, stall, free one out of order, reuse it
        for (int i = 0; i < 4; i++) begin
            do_miss(26'h500 + LA'(i), 2'd0, IW'(i));
        end
        #1;
        chk(miss_ready == 1'b0, "R8", "miss_ready with table full", longint'(miss_ready), 0);
        for (int i = 0; i < 4; i++) push_req(26'h500 + LA'(i), IW'(i), 0, 1'b1, "R4");
        for (int i = 0; i < 4; i++) begin
            for (int s = 1; s < 4; s++) push_req(26'h500 + LA'(i), IW'(i), SW'(s), 1'b0, "R4");
        end
        run(18);
        do_rsp(2, 3); do_rsp(2, 1); do_rsp(2, 0);
        #1;
        chk(miss_ready == 1'b0, "R8", "miss_ready before last sub-block", longint'(miss_ready), 0);
        do_rsp(2, 2);
        #1;
        chk(miss_ready == 1'b1, "R8", "miss_ready after line freed", longint'(miss_ready), 1);
        do_miss(26'h600, 2'd3, 2'd2);
        push_req(26'h600, 2, 3, 1'b1, "R3");
        push_req(26'h600, 2, 0, 1'b0, "R3");
        push_req(26'h600, 2, 1, 1'b0, "R3");
        push_req(26'h600, 2, 2, 1'b0, "R3");
        run(6);
        for (int i = 0; i < 4; i++) begin
            for (int s = 0; s < 4; s++) do_rsp(IW'(i), SW'(s));
        end
        repeat (3) @(posedge clk);
        #2;
        chk(miss_ready == 1'b1, "R8", "miss_ready after all freed", longint'(miss_ready), 1);
        chk(exp_req.size() == 0, "R2", "requests still expected", longint'(exp_req.size()), 0);
        chk(exp_ret.size() == 0, "R7", "returns still expected", longint'(exp_ret.size()), 0);

        summary();
        $finish;
    end

endmodule